// File: doc/BRIEF.md
# I2C Target with Register Pointer

This block is the serial front end of a small register-mapped peripheral. It listens on a two-wire I2C bus, recognises its own 7-bit device address, and turns each data byte of a transfer into a single-cycle read or write strobe toward a register map of 26 byte locations, at addresses 00h to 19h. The block keeps one internal register pointer. The host sets this pointer with the first byte of every write transfer. After that, each byte moves the pointer forward, with three exceptions:

- Location 00h never advances. This lets a host poll a status byte again and again.
- Any pointer value the host loads above the start of the message area (07h) is pulled down to 07h.
- Once the pointer has moved past 19h, write bytes are dropped and read bytes return FFh.

The upper five bits of the device address are fixed. The lowest two come from strap inputs, so four of these blocks can share one bus. SCL and SDA pass through a two-stage synchronizer into the system clock domain. The block pulls SDA low by asserting an open-drain enable. The block emits a one-cycle end-of-transfer pulse when a transfer that addressed it is ended by a STOP or a repeated START. Downstream logic can use this pulse to discard a message that was only partly transferred.

Top module: `i2c_regptr_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {01101, strap_a[1], strap_a[0]}, with the bit received first as bit 6 and the eighth bit as read(1)/write(0). On any other address it leaves SDA released during the acknowledge bit, goes idle until the next START, and issues no register strobe.
- R2: In a write transfer, the first byte after the address loads the pointer from its bits 4:0, and bits 7:5 are ignored. A loaded value above 07h becomes 07h. This byte produces no register strobe.
- R3: Each later write byte produces one reg_wr pulse, with reg_addr equal to the pointer and reg_wdata equal to the byte. The pointer then moves up by one. Every write byte is acknowledged.
- R4: The pointer never advances from 00h. Reads there return location 00h again and again. A write byte received while the pointer is 00h reloads the pointer under the R2 rule.
- R5: A read transfer that is not preceded by a pointer write starts at the pointer value left by the previous transfer. Every transferred read byte advances the pointer.
- R6: After the pointer has moved past 19h, it stays at 1Ah. There, write bytes are acknowledged but produce no strobe, and read bytes return FFh without a reg_rd pulse.
- R7: When the master does not acknowledge a read byte, the block releases SDA and does not drive it again until a new START. The pointer still advances for that byte.
- R8: xfer_end is high for exactly one clock after a STOP or repeated START that ends a transfer whose address matched. It stays low for transfers that did not match.
- R9: After reset, SDA is released, no strobe or xfer_end is active, and the pointer is 00h.
- R10: A repeated START in the middle of a transfer restarts address reception. The pointer written before the repeated START is kept for the following read.
- R11: The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| strap_a | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 5 | Current pointer, the address for the strobes |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd | output | 1 | One-cycle read strobe; reg_rdata is sampled in the same cycle |
| reg_rdata | input | 8 | Combinational read data from the register map |
| xfer_end | output | 1 | One-cycle pulse when an addressed transfer ends |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for deliberate START and STOP conditions. They also assume that each SCL phase lasts well beyond the three-cycle synchronizer and edge-detect delay. Under these conditions the check that SDA drive changes only while SCL is low, and the checks on the strobe ranges, hold. The bench master holds every quarter bit for eight clocks and moves its own data only in the low phase. It always ends a read with a not-acknowledge before a STOP, so it never tries to signal STOP or START while the block is driving SDA low.

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter logic [4:0] DEV_PREFIX  = 5'b01101,
  parameter int         LAST_REG    = 25,
  parameter int         DATA_BASE   = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  scl_i,
  input  logic                                  sda_i,
  input  logic [1:0]                            strap_a,
  output logic                                  sda_oe,
  output logic [$clog2(LAST_REG+2)-1:0]         reg_addr,
  output logic                                  reg_wr,
  output logic [7:0]                            reg_wdata,
  output logic                                  reg_rd,
  input  logic [7:0]                            reg_rdata,
  output logic                                  xfer_end
);
  localparam int PTR_W = $clog2(LAST_REG+2);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_REG);
  localparam logic [PTR_W-1:0] BASE_P = PTR_W'(DATA_BASE);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t        state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       rw, first_byte, active, oe_q, m_ack, xfer_q;
  logic [PTR_W-1:0] ptr, ptr_next, ld_val;
  logic [6:0] my_addr;
  logic       ptr_valid, byte_in_done, ptr_load, rd_load;
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1; sda_sync <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign my_addr      = {DEV_PREFIX, strap_a};
  assign ptr_valid    = (ptr <= LAST_P);
  assign ptr_next     = (ptr == '0 || !ptr_valid) ? ptr : ptr + 1'b1;
  assign ld_val       = (shreg[PTR_W-1:0] > BASE_P) ? BASE_P : shreg[PTR_W-1:0];
  assign byte_in_done = (state == S_WR) && scl_fall && (bit_cnt == 4'd8);
  assign ptr_load     = byte_in_done && (first_byte || ptr == '0);
  assign rd_load      = scl_fall && (((state == S_AACK) && rw) || ((state == S_RACK) && m_ack));
  assign rd_byte      = ptr_valid ? reg_rdata : 8'hFF;

  assign reg_addr  = ptr;
  assign reg_wdata = shreg;
  assign reg_wr    = byte_in_done && !ptr_load && ptr_valid;
  assign reg_rd    = rd_load && ptr_valid;
  assign sda_oe    = oe_q;
  assign xfer_end  = xfer_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bit_cnt <= '0; shreg <= '0; rw <= 1'b0;
      first_byte <= 1'b0; active <= 1'b0; oe_q <= 1'b0; m_ack <= 1'b0; xfer_q <= 1'b0;
    end else begin
      xfer_q <= (start_det | stop_det) & active;
      if (start_det) begin
        state <= S_ADDR; bit_cnt <= '0; oe_q <= 1'b0; first_byte <= 1'b1; active <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE; oe_q <= 1'b0; active <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (shreg[7:1] == my_addr) begin
                  oe_q <= 1'b1; rw <= shreg[0]; active <= 1'b1; state <= S_AACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                oe_q <= 1'b1; first_byte <= 1'b0; state <= S_WACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            if (rw) begin
              shreg <= rd_byte; oe_q <= ~rd_byte[7]; bit_cnt <= 4'd1; state <= S_RD;
            end else begin
              oe_q <= 1'b0; bit_cnt <= '0; state <= S_WR;
            end
          end
          S_WACK: if (scl_fall) begin
            oe_q <= 1'b0; bit_cnt <= '0; state <= S_WR;
          end
          S_RD: if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              oe_q <= 1'b0; state <= S_RACK;
            end else begin
              oe_q    <= ~shreg[6];
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          S_RACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            else if (scl_fall) begin
              if (m_ack) begin
                shreg <= rd_byte; oe_q <= ~rd_byte[7]; bit_cnt <= 4'd1; state <= S_RD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr <= '0;
    else if (byte_in_done) ptr <= ptr_load ? ld_val : ptr_next;
    else if (state == S_RACK && scl_rise) ptr <= ptr_next;

  AST_ADDR_NOMATCH_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && bit_cnt == 4'd8 && shreg[7:1] != my_addr) |=> !sda_oe); // R1
  AST_LOAD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (reg_addr <= BASE_P)); // R2
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_addr == $past(reg_addr) + 1'b1)); // R3
  AST_WR_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr != '0)); // R4
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (reg_addr <= LAST_P)); // R6
  AST_PTR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr <= LAST_P + 1'b1); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R3
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK && scl_fall && !m_ack) |=> (!sda_oe && state == S_IDLE)); // R7
  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end); // R8
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R11
endmodule

// File: tb/i2c_regptr_target_tb_top.sv
module i2c_regptr_target_tb_top;
  localparam int Q = 8;
  localparam logic [7:0] STATUS = 8'h5A;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl_m, m_oe;
  logic [1:0] strap;
  logic dut_oe, reg_wr, reg_rd, xfer_end;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, map_rdata;
  wire  sda_line = ~(m_oe | dut_oe);

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, xe_cnt = 0;
  logic [7:0] mem [0:25];
  logic [7:0] exp_mem [0:25];
  bit done = 0;

  i2c_regptr_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_a(strap),
    .sda_oe(dut_oe), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(map_rdata), .xfer_end(xfer_end));

  assign map_rdata = (reg_addr <= 5'd25) ? mem[reg_addr] : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 26; i++) mem[i] <= (i == 0) ? STATUS : 8'(8'h30 + i);
    end else begin
      if (reg_wr && reg_addr <= 5'd25) mem[reg_addr] <= reg_wdata;
      if (reg_wr) wr_cnt <= wr_cnt + 1;
      if (reg_rd) rd_cnt <= rd_cnt + 1;
      if (xfer_end) xe_cnt <= xe_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait; repeat (Q) @(negedge clk); endtask

  task automatic i2c_start;
    m_oe = 0; qwait; scl_m = 1; qwait; m_oe = 1; qwait; scl_m = 0; qwait;
  endtask

  task automatic i2c_stop;
    m_oe = 1; qwait; scl_m = 1; qwait; m_oe = 0; qwait;
  endtask

  task automatic bit_clk(input logic drive_low, output logic smp);
    m_oe = drive_low; qwait; scl_m = 1; qwait; smp = sda_line; qwait; scl_m = 0; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_clk(~b[i], s);
    bit_clk(1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_clk(1'b0, s); b[i] = s; end
    bit_clk(~nack, s);
    m_oe = 0;
  endtask

  function automatic int clampv(input int v);
    return ((v & 31) > 7) ? 7 : (v & 31);
  endfunction

  logic [6:0] dev;
  logic ack;
  logic [7:0] rb, pb, dat;
  int ep, w0, r0, x0;

  task automatic addr(input logic rd);
    i2c_start; send_byte({dev, rd}, ack);
    chk(ack == 1'b1, "R1 own address ack", ack, 1);
  endtask

  initial begin
    scl_m = 1; m_oe = 0; strap = 2'b10; rst_n = 0;
    for (int i = 0; i < 26; i++) exp_mem[i] = (i == 0) ? STATUS : 8'(8'h30 + i);
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    dev = {5'b01101, strap};
    chk(dut_oe == 0 && reg_wr == 0 && reg_rd == 0 && xfer_end == 0, "R9 reset outputs",
        {dut_oe, reg_wr, reg_rd, xfer_end}, 0);
    addr(1); recv_byte(0, rb);
    chk(rb == STATUS, "R9 pointer 00h after reset", rb, STATUS);
    recv_byte(1, rb); i2c_stop;
    chk(rb == STATUS, "R4 no advance at 00h", rb, STATUS);

    // R1: address sweep
    x0 = xe_cnt; w0 = wr_cnt;
    for (int a = 0; a < 128; a++) begin
      i2c_start; send_byte({7'(a), 1'b0}, ack); i2c_stop;
      chk(ack == (7'(a) == dev), "R1 address sweep", ack, (7'(a) == dev));
    end
    chk(xe_cnt - x0 == 1, "R8 pulse only on matched transfer", xe_cnt - x0, 1);
    chk(wr_cnt == w0, "R1 no strobe", wr_cnt - w0, 0);
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      i2c_start; send_byte({5'b01101, 2'(s), 1'b0}, ack); i2c_stop;
      chk(ack == 1'b1, "R1 strap select", ack, 1);
    end
    strap = 2'b10;

    // R2/R3/R4: pointer load sweep
    ep = 0;
    for (int v = 0; v < 32; v++) begin
      pb = 8'(v) | (v[0] ? 8'hE0 : 8'h00);
      dat = 8'(8'hA0 + v);
      w0 = wr_cnt;
      addr(0); send_byte(pb, ack); send_byte(dat, ack);
      chk(ack == 1'b1, "R3 data byte ack", ack, 1);
      i2c_stop;
      ep = clampv(v);
      if (ep == 0) ep = clampv(int'(dat));
      else begin exp_mem[ep] = dat; ep++; end
      chk(wr_cnt - w0 == ((v == 0) ? 0 : 1), "R3 write strobe count", wr_cnt - w0, (v == 0) ? 0 : 1);
      addr(1); recv_byte(1, rb); i2c_stop;
      chk(rb == exp_mem[ep], "R2 pointer load and clamp", rb, exp_mem[ep]);
      if (ep != 0) ep++;
    end

    // R5: read continues from last pointer
    addr(1); recv_byte(0, rb);
    chk(rb == exp_mem[ep], "R5 continue read 1", rb, exp_mem[ep]);
    recv_byte(1, rb); i2c_stop;
    chk(rb == exp_mem[ep + 1], "R5 continue read 2", rb, exp_mem[ep + 1]);

    // R6: run past the top of the map
    w0 = wr_cnt;
    addr(0); send_byte(8'h07, ack);
    for (int i = 0; i < 21; i++) begin
      send_byte(8'(8'h10 + i), ack);
      if (i < 19) exp_mem[7 + i] = 8'(8'h10 + i);
    end
    chk(ack == 1'b1, "R6 dropped byte still acked", ack, 1);
    i2c_stop;
    chk(wr_cnt - w0 == 19, "R6 writes past 19h dropped", wr_cnt - w0, 19);
    r0 = rd_cnt;
    addr(0); send_byte(8'h07, ack); i2c_start; send_byte({dev, 1'b1}, ack);
    for (int i = 0; i < 21; i++) begin
      recv_byte(i == 20, rb);
      if (i < 19) chk(rb == exp_mem[7 + i], "R3 auto-increment readback", rb, exp_mem[7 + i]);
      else chk(rb == 8'hFF, "R6 read past 19h", rb, 8'hFF);
    end
    i2c_stop;
    chk(rd_cnt - r0 == 19, "R6 no read strobe past 19h", rd_cnt - r0, 19);

    // R4: data byte at 00h reloads the pointer; repeated polling
    addr(0); send_byte(8'h00, ack); send_byte(8'h05, ack); i2c_stop;
    addr(1); recv_byte(1, rb); i2c_stop;
    chk(rb == exp_mem[5], "R4 reload at 00h", rb, exp_mem[5]);
    addr(0); send_byte(8'h00, ack); i2c_stop;
    addr(1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i == 2, rb);
      chk(rb == STATUS, "R4 poll 00h", rb, STATUS);
    end
    i2c_stop;

    // R7: master not-acknowledge
    addr(0); send_byte(8'h07, ack); i2c_stop;
    addr(1); recv_byte(1, rb);
    chk(rb == exp_mem[7], "R7 nacked byte", rb, exp_mem[7]);
    recv_byte(1, rb);
    chk(rb == 8'hFF, "R7 SDA released after nack", rb, 8'hFF);
    i2c_stop;
    addr(1); recv_byte(1, rb); i2c_stop;
    chk(rb == exp_mem[8], "R7 pointer advanced past nacked byte", rb, exp_mem[8]);

    // R10/R8: repeated start
    x0 = xe_cnt;
    addr(0); send_byte(8'h07, ack);
    i2c_start; send_byte({dev, 1'b1}, ack);
    chk(ack == 1'b1, "R10 address after repeated start", ack, 1);
    recv_byte(1, rb); i2c_stop;
    chk(rb == exp_mem[7], "R10 pointer kept across repeated start", rb, exp_mem[7]);
    repeat (4) @(negedge clk);
    chk(xe_cnt - x0 == 2, "R8 pulse on repeated start and stop", xe_cnt - x0, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule